// File: doc/BRIEF.md
# Vector Length CSR Unit

This unit holds the vector-length state of a scalar core that runs a vector-style extension. It keeps four held values: the maximum vector length, the current vector length, a source element offset and a destination element offset. It also has a plain configuration word. A single CSR access port reaches all of them. A request carries an address, a write enable and write data. One cycle later the unit returns the read data and an illegal-access flag.

Lengths are stored in the range 1 to XLEN. Software writes them in minus-one form, so the unit adds one and clamps the result. A packed status word reads and writes every field in one access. A write to that word applies its fields in a fixed order: the maximum length first, then the current length clamped to the new maximum, then the offsets clamped to the new current length minus one.

Most addresses return the value held before the write. The two length registers differ: a swap access to either one returns the value held after the write. Software therefore sees the clamped result at once. The four held values are also driven out as ports, so the datapath can use them.

Top module: `vlcsr_top`

## Requirements
- R1: After reset, the maximum length and the current length are both 1, both offsets are 0 and the configuration word is 0.
- R2: A write to address 0x4F1 sets the maximum length to the write data plus one, capped at XLEN (64). All-ones write data yields 64.
- R3: A write to address 0x4F0 sets the current length to the smaller of the maximum length and the write data plus one. The maximum length and both offsets keep their values.
- R4: The status word at address 0x4F2 uses these fields: bits 5:0 hold the maximum length minus one, bits 11:6 hold the current length minus one, bits 17:12 hold the source offset and bits 23:18 hold the destination offset. A write first sets the maximum length to field 5:0 plus one. It then sets the current length to field 11:6 plus one, clamped to that new maximum.
- R5: On a status-word write, each offset is set to its field, limited to at most the newly written current length minus one.
- R6: A read of the status word returns both lengths in minus-one form, the offsets unchanged, and zero in bits 63:24.
- R7: A read of address 0x4F0 or 0x4F1 returns the stored length (1 to 64), zero-extended.
- R8: A write access to address 0x4F0 or 0x4F1 returns the value after the write. A write access to the status word or the configuration word returns the value before the write.
- R9: The configuration word at address 0x4F3 is a full 64-bit read/write register. Writing it changes no length or offset.
- R10: An access to any other address sets the illegal flag with the response, returns zero data and changes no held value.
- R11: Every access produces exactly one response, with the valid flag high in the following cycle. Back-to-back accesses are accepted in every cycle. No response appears without an access.
- R12: Bits 63:24 of a status-word write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_valid_i | input | 1 | Access request this cycle |
| csr_we_i | input | 1 | Access writes csr_wdata_i |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | Write data |
| csr_rvalid_o | output | 1 | Response valid, one cycle after the request |
| csr_rdata_o | output | XLEN | Read data of the response |
| csr_illegal_o | output | 1 | Response belongs to an unmapped address |
| vl_o | output | $clog2(XLEN)+1 | Current vector length |
| mvl_o | output | $clog2(XLEN)+1 | Maximum vector length |
| src_off_o | output | $clog2(XLEN) | Source element offset |
| dst_off_o | output | $clog2(XLEN) | Destination element offset |

## Verification
The assertions check four things on every cycle: the maximum length stays in range, a length write leaves the current length within 1 to the maximum, the offsets stay below the current length after a status-word write, and the read data for a current-length swap equals the length that was just stored. They also check that an illegal access leaves every held value unchanged and that each request gets exactly one response. Only the bench scenarios can show the exact arithmetic. They cover the minus-one encoding and the saturation at 64 for all-ones data, the field order when a status write clamps the current length and then the offsets, and the choice between the pre-write and post-write value on each address. They also show that the configuration word has no side effects.

// File: rtl/vlcsr_pkg.sv
package vlcsr_pkg;

    localparam logic [11:0] ADDR_VL    = 12'h4F0;
    localparam logic [11:0] ADDR_MVL   = 12'h4F1;
    localparam logic [11:0] ADDR_STATE = 12'h4F2;
    localparam logic [11:0] ADDR_CFG   = 12'h4F3;

    // One-hot select positions
    localparam int SEL_VL    = 0;
    localparam int SEL_MVL   = 1;
    localparam int SEL_STATE = 2;
    localparam int SEL_CFG   = 3;
    localparam int SEL_NUM   = 4;

    typedef logic [SEL_NUM-1:0] sel_t;

endpackage

// File: rtl/vlcsr_decode.sv
module vlcsr_decode
    import vlcsr_pkg::*;
(
    input  logic [11:0] addr_i,
    output sel_t        sel_o,
    output logic        unmapped_o
);
    always_comb begin
        sel_o            = '0;
        sel_o[SEL_VL]    = (addr_i == ADDR_VL);
        sel_o[SEL_MVL]   = (addr_i == ADDR_MVL);
        sel_o[SEL_STATE] = (addr_i == ADDR_STATE);
        sel_o[SEL_CFG]   = (addr_i == ADDR_CFG);
        unmapped_o       = ~|sel_o;
    end
endmodule

// File: rtl/vlcsr_lenclamp.sv
module vlcsr_lenclamp #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]          wdata_i,
    input  logic [$clog2(XLEN):0]    mvl_i,
    output logic [$clog2(XLEN):0]    mvl_wr_o,
    output logic [$clog2(XLEN):0]    vl_wr_o,
    output logic [$clog2(XLEN):0]    st_mvl_o,
    output logic [$clog2(XLEN):0]    st_vl_o,
    output logic [$clog2(XLEN)-1:0]  st_src_o,
    output logic [$clog2(XLEN)-1:0]  st_dst_o
);
    localparam int OFF_W = $clog2(XLEN);
    localparam int LEN_W = OFF_W + 1;

    logic [XLEN-1:0]  mvl_ext;
    logic [OFF_W-1:0] f_mvl, f_vl, f_src, f_dst;
    logic [LEN_W-1:0] vl_cand, lim;

    always_comb begin
        mvl_ext = XLEN'(mvl_i);

        // Direct length writes, minus-one encoded, saturating
        if (wdata_i >= XLEN'(XLEN - 1)) mvl_wr_o = LEN_W'(XLEN);
        else                            mvl_wr_o = wdata_i[LEN_W-1:0] + LEN_W'(1);

        if (wdata_i >= mvl_ext - XLEN'(1)) vl_wr_o = mvl_i;
        else                               vl_wr_o = wdata_i[LEN_W-1:0] + LEN_W'(1);

        // Packed word: max length, then current length, then offsets
        f_mvl = wdata_i[OFF_W-1:0];
        f_vl  = wdata_i[2*OFF_W-1:OFF_W];
        f_src = wdata_i[3*OFF_W-1:2*OFF_W];
        f_dst = wdata_i[4*OFF_W-1:3*OFF_W];

        st_mvl_o = {1'b0, f_mvl} + LEN_W'(1);
        vl_cand  = {1'b0, f_vl} + LEN_W'(1);
        st_vl_o  = (vl_cand > st_mvl_o) ? st_mvl_o : vl_cand;
        lim      = st_vl_o - LEN_W'(1);
        st_src_o = ({1'b0, f_src} > lim) ? lim[OFF_W-1:0] : f_src;
        st_dst_o = ({1'b0, f_dst} > lim) ? lim[OFF_W-1:0] : f_dst;
    end
endmodule

// File: rtl/vlcsr_rmux.sv
module vlcsr_rmux
    import vlcsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  sel_t                     sel_i,
    input  logic [$clog2(XLEN):0]    vl_i,
    input  logic [$clog2(XLEN):0]    mvl_i,
    input  logic [$clog2(XLEN)-1:0]  src_i,
    input  logic [$clog2(XLEN)-1:0]  dst_i,
    input  logic [XLEN-1:0]          cfg_i,
    output logic [XLEN-1:0]          rdata_o
);
    localparam int OFF_W = $clog2(XLEN);
    localparam int LEN_W = OFF_W + 1;

    logic [LEN_W-1:0] mvl_m1, vl_m1;

    always_comb begin
        mvl_m1  = mvl_i - LEN_W'(1);
        vl_m1   = vl_i - LEN_W'(1);
        rdata_o = '0;
        if (sel_i[SEL_VL]) begin
            rdata_o = XLEN'(vl_i);
        end else if (sel_i[SEL_MVL]) begin
            rdata_o = XLEN'(mvl_i);
        end else if (sel_i[SEL_STATE]) begin
            rdata_o[OFF_W-1:0]         = mvl_m1[OFF_W-1:0];
            rdata_o[2*OFF_W-1:OFF_W]   = vl_m1[OFF_W-1:0];
            rdata_o[3*OFF_W-1:2*OFF_W] = src_i;
            rdata_o[4*OFF_W-1:3*OFF_W] = dst_i;
        end else if (sel_i[SEL_CFG]) begin
            rdata_o = cfg_i;
        end
    end
endmodule

// File: rtl/vlcsr_top.sv
module vlcsr_top
    import vlcsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     csr_valid_i,
    input  logic                     csr_we_i,
    input  logic [11:0]              csr_addr_i,
    input  logic [XLEN-1:0]          csr_wdata_i,
    output logic                     csr_rvalid_o,
    output logic [XLEN-1:0]          csr_rdata_o,
    output logic                     csr_illegal_o,
    output logic [$clog2(XLEN):0]    vl_o,
    output logic [$clog2(XLEN):0]    mvl_o,
    output logic [$clog2(XLEN)-1:0]  src_off_o,
    output logic [$clog2(XLEN)-1:0]  dst_off_o
);
    localparam int OFF_W = $clog2(XLEN);
    localparam int LEN_W = OFF_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0] mvl;
        logic [LEN_W-1:0] vl;
        logic [OFF_W-1:0] src;
        logic [OFF_W-1:0] dst;
        logic [XLEN-1:0]  cfg;
        logic             rvalid;
        logic             illegal;
        logic [XLEN-1:0]  rdata;
    } st_t;

    function automatic st_t reset_state();
        st_t s;
        s     = '0;
        s.mvl = LEN_W'(1);
        s.vl  = LEN_W'(1);
        return s;
    endfunction

    st_t cur_q, cur_d;

    sel_t             sel;
    logic             unmapped;
    logic [LEN_W-1:0] mvl_wr, vl_wr, st_mvl, st_vl;
    logic [OFF_W-1:0] st_src, st_dst;
    logic [XLEN-1:0]  rd_pre;
    logic             post_read;

    vlcsr_decode u_dec (
        .addr_i     (csr_addr_i),
        .sel_o      (sel),
        .unmapped_o (unmapped)
    );

    vlcsr_lenclamp #(.XLEN(XLEN)) u_clamp (
        .wdata_i  (csr_wdata_i),
        .mvl_i    (cur_q.mvl),
        .mvl_wr_o (mvl_wr),
        .vl_wr_o  (vl_wr),
        .st_mvl_o (st_mvl),
        .st_vl_o  (st_vl),
        .st_src_o (st_src),
        .st_dst_o (st_dst)
    );

    vlcsr_rmux #(.XLEN(XLEN)) u_rmux (
        .sel_i   (sel),
        .vl_i    (cur_q.vl),
        .mvl_i   (cur_q.mvl),
        .src_i   (cur_q.src),
        .dst_i   (cur_q.dst),
        .cfg_i   (cur_q.cfg),
        .rdata_o (rd_pre)
    );

    always_comb begin
        cur_d         = cur_q;
        cur_d.rvalid  = csr_valid_i;
        cur_d.illegal = csr_valid_i & unmapped;
        cur_d.rdata   = '0;
        post_read     = csr_we_i & (sel[SEL_VL] | sel[SEL_MVL]);
        if (csr_valid_i && !unmapped) begin
            if (csr_we_i) begin
                if (sel[SEL_VL]) begin
                    cur_d.vl = vl_wr;
                end else if (sel[SEL_MVL]) begin
                    cur_d.mvl = mvl_wr;
                end else if (sel[SEL_STATE]) begin
                    cur_d.mvl = st_mvl;
                    cur_d.vl  = st_vl;
                    cur_d.src = st_src;
                    cur_d.dst = st_dst;
                end else if (sel[SEL_CFG]) begin
                    cur_d.cfg = csr_wdata_i;
                end
            end
            // Length swaps report the stored (clamped) result
            if (post_read) begin
                cur_d.rdata = sel[SEL_VL] ? XLEN'(cur_d.vl) : XLEN'(cur_d.mvl);
            end else begin
                cur_d.rdata = rd_pre;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cur_q <= reset_state();
        else         cur_q <= cur_d;
    end

    assign csr_rvalid_o  = cur_q.rvalid;
    assign csr_rdata_o   = cur_q.rdata;
    assign csr_illegal_o = cur_q.illegal;
    assign vl_o          = cur_q.vl;
    assign mvl_o         = cur_q.mvl;
    assign src_off_o     = cur_q.src;
    assign dst_off_o     = cur_q.dst;

endmodule

// File: rtl/vlcsr_checker.sv
module vlcsr_checker
    import vlcsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     csr_valid_i,
    input logic                     csr_we_i,
    input logic [11:0]              csr_addr_i,
    input logic                     csr_rvalid_o,
    input logic [XLEN-1:0]          csr_rdata_o,
    input logic                     csr_illegal_o,
    input logic [$clog2(XLEN):0]    vl_o,
    input logic [$clog2(XLEN):0]    mvl_o,
    input logic [$clog2(XLEN)-1:0]  src_off_o,
    input logic [$clog2(XLEN)-1:0]  dst_off_o
);
    localparam int LEN_W = $clog2(XLEN) + 1;

    // R2: maximum length always within 1..XLEN
    assert_mvl_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mvl_o >= LEN_W'(1)) && (mvl_o <= LEN_W'(XLEN)));

    // R3: a current-length write leaves it within 1..max
    assert_vl_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_valid_i && csr_we_i && csr_addr_i == ADDR_VL)
        |=> (vl_o >= LEN_W'(1)) && (vl_o <= mvl_o));

    // R5: offsets below current length after a packed-word write
    assert_offs_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_valid_i && csr_we_i && csr_addr_i == ADDR_STATE)
        |=> (LEN_W'(src_off_o) < vl_o) && (LEN_W'(dst_off_o) < vl_o));

    // R8: current-length swap returns the stored post-write value
    assert_swap_post_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_valid_i && csr_we_i && csr_addr_i == ADDR_VL)
        |=> csr_rdata_o == XLEN'(vl_o));

    // R10: illegal access changes no held value
    assert_illegal_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_illegal_o |-> ($stable(vl_o) && $stable(mvl_o)
                           && $stable(src_off_o) && $stable(dst_off_o)));

    // R11: one response per request, none without
    assert_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_valid_i |=> csr_rvalid_o);
    assert_noresp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !csr_valid_i |=> !csr_rvalid_o);

endmodule

bind vlcsr_top vlcsr_checker #(.XLEN(XLEN)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .csr_valid_i   (csr_valid_i),
    .csr_we_i      (csr_we_i),
    .csr_addr_i    (csr_addr_i),
    .csr_rvalid_o  (csr_rvalid_o),
    .csr_rdata_o   (csr_rdata_o),
    .csr_illegal_o (csr_illegal_o),
    .vl_o          (vl_o),
    .mvl_o         (mvl_o),
    .src_off_o     (src_off_o),
    .dst_off_o     (dst_off_o)
);

// File: tb/vlcsr_top_tb_top.sv
`timescale 1ns/1ps
module vlcsr_top_tb_top;
    localparam int XLEN = 64;
    localparam logic [11:0] A_VL = 12'h4F0, A_MVL = 12'h4F1, A_ST = 12'h4F2, A_CFG = 12'h4F3;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst_n, valid, we;
    logic [11:0] addr;
    logic [63:0] wdata, rdata;
    logic rvalid, illegal;
    logic [6:0] vl, mvl;
    logic [5:0] src, dst;

    vlcsr_top #(.XLEN(XLEN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_valid_i(valid), .csr_we_i(we),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rvalid_o(rvalid),
        .csr_rdata_o(rdata), .csr_illegal_o(illegal), .vl_o(vl), .mvl_o(mvl),
        .src_off_o(src), .dst_off_o(dst)
    );

    typedef struct {
        logic [63:0] rdata;
        logic        illegal;
        logic [6:0]  vl, mvl;
        logic [5:0]  src, dst;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state
    longint unsigned m_mvl = 1, m_vl = 1, m_src = 0, m_dst = 0;
    logic [63:0] m_cfg = '0;

    function automatic logic [63:0] m_read(logic [11:0] a);
        case (a)
            A_VL:  return 64'(m_vl);
            A_MVL: return 64'(m_mvl);
            A_ST:  return 64'((m_mvl - 1) | ((m_vl - 1) << 6) | (m_src << 12) | (m_dst << 18));
            A_CFG: return m_cfg;
            default: return 64'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic access(input logic [11:0] a, input bit w, input logic [63:0] wd, input string tag);
        exp_t e;
        logic [63:0] pre;
        bit legal;
        longint unsigned fm, fv, fs, fd;
        legal = (a == A_VL) || (a == A_MVL) || (a == A_ST) || (a == A_CFG);
        pre = m_read(a);
        if (w && legal) begin
            case (a)
                A_MVL: m_mvl = (wd >= 64'd63) ? 64 : wd + 1;
                A_VL:  m_vl  = (wd + 1 > m_mvl || wd == '1) ? m_mvl : wd + 1;
                A_ST: begin
                    fm = wd[5:0]; fv = wd[11:6]; fs = wd[17:12]; fd = wd[23:18];
                    m_mvl = fm + 1;
                    m_vl  = (fv + 1 < m_mvl) ? fv + 1 : m_mvl;
                    m_src = (fs < m_vl - 1) ? fs : m_vl - 1;
                    m_dst = (fd < m_vl - 1) ? fd : m_vl - 1;
                end
                default: m_cfg = wd;
            endcase
        end
        e.rdata   = !legal ? 64'd0 : ((w && (a == A_VL || a == A_MVL)) ? m_read(a) : pre);
        e.illegal = !legal;
        e.vl = 7'(m_vl); e.mvl = 7'(m_mvl); e.src = 6'(m_src); e.dst = 6'(m_dst);
        e.tag = tag;
        @(negedge clk);
        valid = 1'b1; we = w; addr = a; wdata = wd;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid = 1'b0; we = 1'b0;
        end
    endtask

    // Monitor: compare every response against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R11 unexpected response", "rvalid=1", "rvalid=0");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(rdata == e.rdata && illegal == e.illegal && vl == e.vl &&
                    mvl == e.mvl && src == e.src && dst == e.dst, e.tag,
                    $sformatf("rd=%h ill=%0d vl=%0d mvl=%0d src=%0d dst=%0d",
                              rdata, illegal, vl, mvl, src, dst),
                    $sformatf("rd=%h ill=%0d vl=%0d mvl=%0d src=%0d dst=%0d",
                              e.rdata, e.illegal, e.vl, e.mvl, e.src, e.dst));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; valid = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vl == 7'd1 && mvl == 7'd1 && src == 6'd0 && dst == 6'd0 && !rvalid, "R1 reset state",
            $sformatf("vl=%0d mvl=%0d src=%0d dst=%0d rv=%0d", vl, mvl, src, dst, rvalid),
            "vl=1 mvl=1 src=0 dst=0 rv=0");

        access(A_CFG, 0, '0, "R1 cfg reset read");
        access(A_VL,  0, '0, "R7 read VL");
        access(A_MVL, 0, '0, "R7 read MVL");
        access(A_ST,  0, '0, "R6 read STATE at reset");
        access(A_MVL, 1, 64'd15, "R2 R8 MVL write 15");
        access(A_MVL, 1, 64'd0,  "R2 MVL write 0");
        access(A_MVL, 1, 64'd100, "R2 MVL write 100 capped");
        access(A_MVL, 1, '1, "R2 MVL write all-ones");
        access(A_MVL, 1, 64'd62, "R2 MVL write 62");
        access(A_VL,  1, 64'd5, "R3 R8 VL write 5");
        access(A_VL,  1, 64'd200, "R3 VL write 200 clamped");
        access(A_MVL, 1, 64'd7, "R2 MVL write 7");
        access(A_VL,  1, 64'd20, "R3 VL clamped to MVL 8");
        access(A_VL,  0, '0, "R7 read VL 8");
        // mvl field 9, vl field 30, src 40, dst 3, upper bits set
        access(A_ST, 1, {40'hFF_FFFF_FFFF, 6'd3, 6'd40, 6'd30, 6'd9},
               "R4 R5 R8 R12 STATE write clamps");
        access(A_ST, 0, '0, "R6 read STATE after clamp");
        access(A_ST, 1, {40'd0, 6'd0, 6'd63, 6'd63, 6'd63}, "R4 STATE write max fields");
        access(A_ST, 0, '0, "R6 read STATE max fields");
        access(A_VL, 1, 64'd2, "R3 VL write keeps offsets");
        access(A_ST, 1, {40'd0, 6'd50, 6'd1, 6'd20, 6'd4}, "R4 R5 vl field above mvl");
        access(A_CFG, 1, 64'hDEAD_BEEF_0123_4567, "R8 R9 CFG write returns old");
        access(A_CFG, 1, 64'h8000_0000_0000_0001, "R9 CFG write returns previous");
        access(A_CFG, 0, '0, "R9 CFG read");
        access(12'h4F4, 1, 64'd3, "R10 unmapped write");
        access(12'h4D0, 0, '0, "R10 unmapped read");
        access(12'h000, 1, '1, "R10 unmapped write zero addr");
        access(A_ST, 0, '0, "R10 state intact after unmapped");
        idle(3);
        chk(!rvalid, "R11 no response when idle", $sformatf("%0d", rvalid), "0");
        chk(sbq.size() == 0, "R11 every request answered", $sformatf("%0d", sbq.size()), "0");
        finish_run();
    end
endmodule